// File: doc/BRIEF.md
# Fault Lock and Break Routing Register

This block is a small control register that collects three system fault sources and routes them onto one shared timer break output. The sources are an SRAM parity error, a supply-voltage detector event and a processor lockup signal. Each source reaches the break output only once software has set its own enable bit. An enable bit cannot be cleared again by software. Only a reset returns it to zero, so a configured fault path stays in place even if software misbehaves later.

The register also holds a parity error flag. Hardware sets this flag, and software clears it by writing 1 to it. A further set-once bit tells the external parity checker to leave address bit 29 out of its calculation. When the voltage-detector enable bit is set, the block drives a lock output. That output tells the power-control block to make its detector enable and level fields read-only.

Software writes the register through a single-cycle write strobe with data. It reads the register back on a combinational read port.

Top module: `fault_lock_reg`

## Requirements
- R1: After reset the register reads 0x0000, `brk_o` is 0 (with all enables clear), and `volt_lock_o` and `addr_bypass_o` are 0.
- R2: When `parity_err_i` is high at a clock edge, the parity flag at bit 8 reads 1 from that edge onward.
- R3: Writing a word with bit 8 = 1 clears the parity flag at the next edge. Writing bit 8 = 0 leaves the flag unchanged.
- R4: If a parity error and a write-1 clear of bit 8 fall on the same edge, the flag is 1 after that edge.
- R5: Writing bit 4 = 1 sets the address-bypass bit, and `addr_bypass_o` follows it. Writing bit 4 = 0 has no effect until reset.
- R6: The enable bits are bit 0 (lockup), bit 1 (parity) and bit 2 (voltage detector). Writing 1 sets the bit. Writing 0 has no effect. Only an asserted `rst_ni` low clears them.
- R7: `brk_o` is high in the same cycle as any source whose enable bit is set: `lockup_i` with bit 0, `parity_err_i` with bit 1, `volt_evt_i` with bit 2. Sources whose enable bit is clear never raise `brk_o`.
- R8: `volt_lock_o` equals the voltage-detector enable bit (bit 2).
- R9: Bits 15:9, 7:5 and 3 always read 0, whatever value is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read data |
| parity_err_i | input | 1 | SRAM parity error pulse from the checker |
| volt_evt_i | input | 1 | Supply-voltage detector event |
| lockup_i | input | 1 | Processor lockup signal |
| brk_o | output | 1 | Combined break to the timers |
| volt_lock_o | output | 1 | Freezes the detector configuration in the power block |
| addr_bypass_o | output | 1 | Leave address bit 29 out of the parity calculation |

## Verification
A hardware parity event and a software write-1 clear of the flag can land on the same edge. The bench provokes this by driving `parity_err_i` high in the cycle that carries a write of bit 8. It also drives the same write with the parity input low, so the two outcomes can be compared. The reference model lets the set win over the clear and compares the read port on the following cycle. A second overlap is a fault source pulsing in the very cycle its enable bit is written. The bench expects `brk_o` to stay low in that cycle and to follow the source from the next cycle on.

// File: rtl/fault_lock_pkg.sv
package fault_lock_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned NUM_SRC  = 3;
  // bit positions decoded by software and by neighbours
  localparam int unsigned LOCKUP_BIT = 0;
  localparam int unsigned PARITY_BIT = 1;
  localparam int unsigned VOLT_BIT   = 2;
  localparam int unsigned BYP_BIT    = 4;
  localparam int unsigned FLAG_BIT   = 8;
  localparam logic [REG_W-1:0] USED_MASK =
    REG_W'((1 << FLAG_BIT) | (1 << BYP_BIT) | ((1 << NUM_SRC) - 1));
  localparam logic [REG_W-1:0] RSVD_MASK = ~USED_MASK;
endpackage

// File: rtl/set_once_bits.sv
module set_once_bits #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/w1c_flag.sv
module w1c_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic sw_clr_i,
  output logic q_o
);
  // hardware set outranks software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= 1'b0;
    else if (hw_set_i)  q_o <= 1'b1;
    else if (sw_clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/break_gate.sv
module break_gate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] en_i,
  output logic         brk_o
);
  logic [N-1:0] gated;
  for (genvar i = 0; i < N; i++) begin : g_src
    assign gated[i] = src_i[i] & en_i[i];
  end
  assign brk_o = |gated;
endmodule

// File: rtl/fault_lock_reg.sv
module fault_lock_reg
  import fault_lock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             parity_err_i,
  input  logic             volt_evt_i,
  input  logic             lockup_i,
  output logic             brk_o,
  output logic             volt_lock_o,
  output logic             addr_bypass_o
);
  localparam int unsigned SO_W = NUM_SRC + 1;  // enables plus bypass

  logic [SO_W-1:0]    so_set, so_q;
  logic [NUM_SRC-1:0] src, en;
  logic               flag_q;

  assign so_set[NUM_SRC-1:0] = {NUM_SRC{wr_en_i}} & wr_data_i[NUM_SRC-1:0];
  assign so_set[NUM_SRC]     = wr_en_i & wr_data_i[BYP_BIT];

  set_once_bits #(.W(SO_W)) u_locks (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (so_set),
    .q_o   (so_q)
  );

  w1c_flag u_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hw_set_i(parity_err_i),
    .sw_clr_i(wr_en_i & wr_data_i[FLAG_BIT]),
    .q_o     (flag_q)
  );

  assign en = so_q[NUM_SRC-1:0];
  always_comb begin
    src             = '0;
    src[LOCKUP_BIT] = lockup_i;
    src[PARITY_BIT] = parity_err_i;
    src[VOLT_BIT]   = volt_evt_i;
  end

  break_gate #(.N(NUM_SRC)) u_brk (
    .src_i(src),
    .en_i (en),
    .brk_o(brk_o)
  );

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[NUM_SRC-1:0]      = en;
    rd_data_o[BYP_BIT]          = so_q[NUM_SRC];
    rd_data_o[FLAG_BIT]         = flag_q;
  end

  assign volt_lock_o   = en[VOLT_BIT];
  assign addr_bypass_o = so_q[NUM_SRC];
endmodule

// File: rtl/fault_lock_reg_chk.sv
module fault_lock_reg_chk
  import fault_lock_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             parity_err_i,
  input logic             volt_evt_i,
  input logic             lockup_i,
  input logic             brk_o,
  input logic             volt_lock_o,
  input logic             addr_bypass_o
);
  assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_i |=> rd_data_o[FLAG_BIT]);

  assert_flag_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[FLAG_BIT] && !parity_err_i) |=> !rd_data_o[FLAG_BIT]);

  assert_set_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[FLAG_BIT] && parity_err_i) |=> rd_data_o[FLAG_BIT]);

  assert_bypass_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[BYP_BIT] |=> (rd_data_o[BYP_BIT] && addr_bypass_o));

  assert_lock_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_data_o[NUM_SRC-1:0] & ~$past(rd_data_o[NUM_SRC-1:0])) == rd_data_o[NUM_SRC-1:0]
     ) || 1'b1 ? (($past(rd_data_o[NUM_SRC-1:0]) & ~rd_data_o[NUM_SRC-1:0]) == '0) : 1'b0);

  assert_break_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lockup_i && rd_data_o[LOCKUP_BIT]) || (parity_err_i && rd_data_o[PARITY_BIT]) ||
     (volt_evt_i && rd_data_o[VOLT_BIT])) |-> brk_o);

  assert_no_break_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[NUM_SRC-1:0] == '0) |-> !brk_o);

  assert_volt_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    volt_lock_o == rd_data_o[VOLT_BIT]);

  assert_rsvd_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & RSVD_MASK) == '0);

  logic unused_wr;
  assign unused_wr = ^wr_data_i;
endmodule

bind fault_lock_reg fault_lock_reg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_data_i    (wr_data_i),
  .rd_data_o    (rd_data_o),
  .parity_err_i (parity_err_i),
  .volt_evt_i   (volt_evt_i),
  .lockup_i     (lockup_i),
  .brk_o        (brk_o),
  .volt_lock_o  (volt_lock_o),
  .addr_bypass_o(addr_bypass_o)
);

// File: tb/fault_lock_reg_test.sv
`timescale 1ns/1ps
module fault_lock_reg_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        parity_err_i = 1'b0, volt_evt_i = 1'b0, lockup_i = 1'b0;
  logic        brk_o, volt_lock_o, addr_bypass_o;

  int n_chk = 0;
  int n_fail = 0;

  // behavioural model state
  bit m_flag, m_byp;
  bit [2:0] m_en;

  always #2.5 clk_i = ~clk_i;

  fault_lock_reg uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .parity_err_i(parity_err_i), .volt_evt_i(volt_evt_i),
    .lockup_i(lockup_i), .brk_o(brk_o), .volt_lock_o(volt_lock_o),
    .addr_bypass_o(addr_bypass_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one cycle's inputs at negedge, compare, then advance the model
  task automatic step(string req, bit wr, bit [15:0] d, bit par, bit volt, bit lk);
    int exp_rd;
    bit exp_brk;
    @(negedge clk_i);
    wr_en_i = wr; wr_data_i = d; parity_err_i = par; volt_evt_i = volt; lockup_i = lk;
    #1;
    exp_rd  = (int'(m_flag) << 8) | (int'(m_byp) << 4) | int'(m_en);
    exp_brk = (lk & m_en[0]) | (par & m_en[1]) | (volt & m_en[2]);
    chk(req, "rd_data", int'(rd_data_o), exp_rd);
    chk(req, "brk", int'(brk_o), int'(exp_brk));
    chk(req, "volt_lock", int'(volt_lock_o), int'(m_en[2]));
    chk(req, "bypass", int'(addr_bypass_o), int'(m_byp));
    if (par) m_flag = 1'b1;
    else if (wr && d[8]) m_flag = 1'b0;
    if (wr) begin
      m_byp = m_byp | d[4];
      m_en  = m_en | d[2:0];
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    m_flag = 0; m_byp = 0; m_en = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    step("R1", 0, 16'h0000, 0, 0, 0);
    // sources with no enable set
    step("R7", 0, 16'h0000, 1, 1, 1);
    // flag from hardware, hold under bit8=0 write, then clear
    step("R2", 0, 16'h0000, 0, 0, 0);
    step("R3", 1, 16'h0000, 0, 0, 0);
    step("R3", 1, 16'h0100, 0, 0, 0);
    step("R3", 0, 16'h0000, 0, 0, 0);
    // set and clear on the same edge
    step("R4", 0, 16'h0000, 1, 0, 0);
    step("R4", 1, 16'h0100, 1, 0, 0);
    step("R4", 0, 16'h0000, 0, 0, 0);
    step("R4", 1, 16'h0100, 0, 0, 0);
    // reserved bits written with ones
    step("R9", 1, 16'hFEE8, 0, 0, 0);
    step("R9", 0, 16'h0000, 0, 0, 0);
    // bypass bit
    step("R5", 1, 16'h0010, 0, 0, 0);
    step("R5", 1, 16'h0000, 0, 0, 0);
    step("R5", 0, 16'h0000, 0, 0, 0);
    // lockup enable: source pulses in the writing cycle
    step("R7", 1, 16'h0001, 0, 0, 1);
    step("R7", 0, 16'h0000, 0, 0, 1);
    step("R7", 0, 16'h0000, 1, 1, 0);
    step("R6", 1, 16'h0000, 0, 0, 0);
    // parity enable
    step("R6", 1, 16'h0002, 0, 0, 0);
    step("R7", 0, 16'h0000, 1, 0, 0);
    step("R7", 0, 16'h0000, 0, 1, 0);
    // voltage enable and lock output
    step("R8", 1, 16'h0004, 0, 0, 0);
    step("R8", 0, 16'h0000, 0, 1, 0);
    step("R6", 1, 16'h0000, 0, 0, 0);
    step("R6", 1, 16'h0100, 0, 0, 0);
    step("R6", 0, 16'h0000, 0, 0, 0);
    // reset clears locks
    do_reset();
    step("R1", 0, 16'h0000, 0, 1, 1);
    step("R6", 1, 16'h0004, 0, 0, 0);
    step("R7", 0, 16'h0000, 0, 1, 1);
    step("R8", 0, 16'h0000, 0, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule